// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block steps through a circular list of transmit descriptors kept in its own small descriptor store. Software fills a descriptor through a 32-bit register and memory port. A descriptor holds a status/control half-word, a length half-word and a buffer pointer. Software then hands the descriptor over by setting its ready flag and writes any value to the kick register. From its current ring position the engine asks a downstream frame sender to send each ready descriptor in turn. It waits for the sender's completion and error flags, writes the result back into the descriptor with the ready flag cleared, and moves on.

The end of the ring is marked by a wrap flag in the last descriptor, not by a count. The descriptor after a wrapped one is the ring base, which is programmed while the engine is held in reset. When the engine meets a descriptor that is not ready, it parks there and keeps that position until the next kick. Completions raise sticky event bits. These are combined with a mask to drive a single interrupt line.

Top module: `tx_ring_engine`

## Requirements
- R1: A send request is issued only for a descriptor whose ready flag (status bit 15) is set, and requests follow ring order. Length comes from word 0 bits [15:0] and the pointer from word 1.
- R2: On completion the status half-word (word 0 bits [31:16]) is written back with bit 15 cleared, bits [14:6] preserved and bits [5:0] replaced by the sender's error flags (0 deferred, 1 heartbeat, 2 late collision, 3 retry limit, 4 underrun, 5 carrier lost). Length and pointer are left unchanged.
- R3: After a descriptor with the wrap flag (status bit 13) completes, the next descriptor examined is the ring base. Otherwise it is the next index, modulo 16.
- R4: A write of any value to the kick register (register 4) starts or resumes processing from the current position. A kick that arrives while a descriptor is in flight is not lost.
- R5: Processing stops at the first descriptor whose ready flag is clear, and the position is kept so that the next kick resumes there.
- R6: Every completion sets the buffer event (event register bit 26). A completion whose last flag (status bit 11) is set also sets the frame event (bit 27).
- R7: Event bits stay set until a one is written to them in the event register (register 1). The interrupt output is the OR of the events ANDed with the mask register (register 2, same bit positions).
- R8: While control register (register 0) bit 0 is set, the engine is held in reset: no request is made and the position is loaded from the ring base register (register 3). Writes to the ring base register are ignored unless bit 0 is set.
- R9: With control bit 1 (enable) clear, no request is issued. A kick received in this state takes effect once enable is set.
- R10: The send request stays asserted, with length and pointer stable, until the sender signals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 8 | Host address: bit 7 set selects descriptor space (bits [4:1] index, bit 0 word), clear selects registers (bits [2:0]) |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data (combinational) |
| snd_req | output | 1 | Send request to the frame sender |
| snd_len | output | 16 | Length of the descriptor being sent |
| snd_ptr | output | 32 | Buffer pointer of the descriptor being sent |
| snd_done | input | 1 | One-cycle completion pulse from the sender |
| snd_err | input | 6 | Error flags that are valid with snd_done |
| irq | output | 1 | Masked event interrupt |

## Verification
The hardest cases to reach are the position-keeping ones. One is resuming at a parked descriptor after a stop. Another is wrapping back to a base other than index 0. A third is a kick that lands while a descriptor is still in flight. The stimulus parks the engine on a descriptor that is not ready, and leaves a ready decoy after the wrapped entry so that a wrong next position sends the wrong pointer. It then reprograms the base under the control reset bit and issues a second kick while the sender is holding off completion.

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  parameter int PTR_W = 32,
  parameter int LEN_W = 16,
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             snd_req,
  output logic [LEN_W-1:0] snd_len,
  output logic [PTR_W-1:0] snd_ptr,
  input  logic             snd_done,
  input  logic [ERR_W-1:0] snd_err,
  output logic             irq
);
  localparam int IW     = $clog2(DEPTH);
  localparam int B_RDY  = 15;
  localparam int B_WRAP = 13;
  localparam int B_LAST = 11;
  localparam int EV_BUF = 26;
  localparam int EV_FRM = 27;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT} state_t;

  logic [15:0]      st_mem  [DEPTH];
  logic [LEN_W-1:0] len_mem [DEPTH];
  logic [PTR_W-1:0] ptr_mem [DEPTH];

  logic [1:0]    ctl_q;
  logic          ev_buf, ev_frm;
  logic [1:0]    mask_q;
  logic [IW-1:0] start_q, pos_q;
  logic          pend_q;
  state_t        state;

  wire          in_rst  = ctl_q[0];
  wire          run     = ctl_q[1] & ~ctl_q[0];
  wire          wr_desc = cfg_we & cfg_addr[AW-1];
  wire          wr_reg  = cfg_we & ~cfg_addr[AW-1];
  wire [IW-1:0] widx    = cfg_addr[IW:1];
  wire          wsel    = cfg_addr[0];
  wire          kick    = wr_reg & (cfg_addr[2:0] == 3'd4);
  wire          wb      = (state == S_WAIT) & snd_done;
  wire [15:0]   cur_st  = st_mem[pos_q];
  wire [15:0]   wb_word = {1'b0, cur_st[14:ERR_W], snd_err};
  wire [IW-1:0] pos_inc = (pos_q == IW'(DEPTH-1)) ? '0 : pos_q + 1'b1;

  assign snd_req = (state == S_WAIT);
  assign snd_len = len_mem[pos_q];
  assign snd_ptr = ptr_mem[pos_q];
  assign irq     = |({ev_frm, ev_buf} & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_mem[i]  <= '0;
        len_mem[i] <= '0;
        ptr_mem[i] <= '0;
      end
    end else begin
      if (wr_desc && !wsel) begin
        st_mem[widx]  <= cfg_wdata[31:16];
        len_mem[widx] <= cfg_wdata[LEN_W-1:0];
      end
      if (wr_desc && wsel) ptr_mem[widx] <= cfg_wdata[PTR_W-1:0];
      if (wb) st_mem[pos_q] <= wb_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      mask_q  <= '0;
      start_q <= '0;
      ev_buf  <= 1'b0;
      ev_frm  <= 1'b0;
    end else begin
      if (wr_reg && cfg_addr[2:0] == 3'd0) ctl_q <= cfg_wdata[1:0];
      if (wr_reg && cfg_addr[2:0] == 3'd2) mask_q <= cfg_wdata[EV_FRM:EV_BUF];
      if (wr_reg && cfg_addr[2:0] == 3'd3 && in_rst) start_q <= cfg_wdata[IW-1:0];
      if (wb) ev_buf <= 1'b1;
      else if (wr_reg && cfg_addr[2:0] == 3'd1 && cfg_wdata[EV_BUF]) ev_buf <= 1'b0;
      if (wb && cur_st[B_LAST]) ev_frm <= 1'b1;
      else if (wr_reg && cfg_addr[2:0] == 3'd1 && cfg_wdata[EV_FRM]) ev_frm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pos_q  <= '0;
      pend_q <= 1'b0;
    end else if (in_rst) begin
      state  <= S_IDLE;
      pos_q  <= start_q;
      pend_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (run && pend_q) begin
            pend_q <= kick;
            state  <= S_CHECK;
          end else begin
            pend_q <= pend_q | kick;
          end
        end
        S_CHECK: begin
          if (!run) begin
            pend_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            pend_q <= pend_q | kick;
            state  <= cur_st[B_RDY] ? S_WAIT : S_IDLE;
          end
        end
        default: begin
          pend_q <= pend_q | kick;
          if (snd_done) begin
            pos_q <= cur_st[B_WRAP] ? start_q : pos_inc;
            state <= S_CHECK;
          end
        end
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr[AW-1]) begin
      if (wsel) cfg_rdata[PTR_W-1:0] = ptr_mem[widx];
      else      cfg_rdata = {st_mem[widx], len_mem[widx]};
    end else begin
      case (cfg_addr[2:0])
        3'd0: cfg_rdata[1:0] = ctl_q;
        3'd1: cfg_rdata[EV_FRM:EV_BUF] = {ev_frm, ev_buf};
        3'd2: cfg_rdata[EV_FRM:EV_BUF] = mask_q;
        3'd3: cfg_rdata[IW-1:0] = start_q;
        default: cfg_rdata = '0;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || in_rst)
    (snd_req && !snd_done) |=> (snd_req && $stable(snd_ptr) && $stable(snd_len)));

  // R8
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> !snd_req);

  // R6
  buf_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_req && snd_done) |=> ev_buf);

  // R3
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb && cur_st[B_WRAP] && !in_rst) |=> (pos_q == start_q));

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb && !in_rst) |=> $stable(pos_q));
endmodule

// File: tb/sim_tx_ring_engine.sv
`timescale 1ns/1ps
module sim_tx_ring_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        snd_req;
  logic [15:0] snd_len;
  logic [31:0] snd_ptr;
  logic        snd_done;
  logic [5:0]  snd_err;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int n_sent  = 0;
  bit finished = 0;
  logic [53:0] exp_q[$];

  always #2.5 clk = ~clk;

  tx_ring_engine u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
                     .snd_req, .snd_len, .snd_ptr, .snd_done, .snd_err, .irq);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic make_desc(input int idx, input logic [15:0] st, input logic [15:0] len,
                           input logic [31:0] ptr, input logic [5:0] err, input bit expect_send);
    if (expect_send) exp_q.push_back({err, len, ptr});
    wr(8'h80 | 8'(idx << 1) | 8'd1, ptr);
    wr(8'h80 | 8'(idx << 1), {st, len});
  endtask

  task automatic wait_sent(input int n);
    for (int i = 0; i < 2000 && n_sent < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // scoreboard monitor and frame-sender model
  initial begin
    logic [53:0] e;
    snd_done = 0; snd_err = 0;
    forever begin
      @(negedge clk);
      if (snd_req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected request", {snd_len, snd_ptr}, 0);
          e = {6'd0, snd_len, snd_ptr};
        end else begin
          e = exp_q.pop_front();
          chk({snd_len, snd_ptr} == e[47:0], "R1 request len/ptr", {snd_len, snd_ptr}, e[47:0]);
        end
        repeat (3) begin
          @(negedge clk);
          chk(snd_req && snd_ptr == e[31:0] && snd_len == e[47:32], "R10 request held",
              {snd_req, snd_len, snd_ptr}, {1'b1, e[47:0]});
        end
        snd_err = e[53:48]; snd_done = 1;
        @(negedge clk);
        snd_done = 0;
        n_sent++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0 && snd_req == 0, "R7 reset outputs", {irq, snd_req}, 0);
    rd(8'h01, d); chk(d == 0, "R7 reset events", d, 0);
    rd(8'h03, d); chk(d == 0, "R8 reset base", d, 0);

    wr(8'h00, 32'h2);
    make_desc(0, 16'h9400, 16'd64,  32'hA000_0000, 6'h01, 1);
    make_desc(1, 16'h9400, 16'd100, 32'hA000_0100, 6'h26, 1);
    make_desc(2, 16'h9C00, 16'd60,  32'hA000_0200, 6'h00, 1);
    wr(8'h04, 32'h0);
    wait_sent(3);
    chk(n_sent == 3, "R5 stop at non-ready", n_sent, 3);
    rd(8'h80, d); chk(d == 32'h1401_0040, "R2 writeback d0", d, 32'h1401_0040);
    rd(8'h82, d); chk(d == 32'h1426_0064, "R2 writeback d1", d, 32'h1426_0064);
    rd(8'h84, d); chk(d == 32'h1C00_003C, "R2 writeback d2", d, 32'h1C00_003C);
    rd(8'h83, d); chk(d == 32'hA000_0100, "R2 pointer kept", d, 32'hA000_0100);
    rd(8'h01, d); chk(d == 32'h0C00_0000, "R6 both events", d, 32'h0C00_0000);
    chk(irq == 0, "R7 masked irq", irq, 0);
    wr(8'h02, 32'h0800_0000);
    @(negedge clk); chk(irq == 1, "R7 frame irq", irq, 1);
    wr(8'h01, 32'h0800_0000);
    rd(8'h01, d); chk(d == 32'h0400_0000, "R7 w1c", d, 32'h0400_0000);
    chk(irq == 0, "R7 irq after clear", irq, 0);
    wr(8'h01, 32'h0C00_0000);

    make_desc(3, 16'hB400, 16'd8, 32'hA000_0300, 6'h10, 1);
    make_desc(4, 16'hBC00, 16'd9, 32'hDEAD_0004, 6'h00, 0);
    wr(8'h04, 32'h1234);
    wait_sent(4);
    chk(n_sent == 4, "R5 resume at parked position", n_sent, 4);
    rd(8'h01, d); chk(d == 32'h0400_0000, "R6 buffer only without last", d, 32'h0400_0000);
    make_desc(0, 16'h9C00, 16'd70, 32'hB000_0000, 6'h00, 1);
    wr(8'h04, 32'h0);
    wait_sent(5);
    chk(n_sent == 5, "R3 wrap to base", n_sent, 5);

    wr(8'h03, 32'h5);
    rd(8'h03, d); chk(d == 0, "R8 base write ignored", d, 0);
    wr(8'h00, 32'h3);
    wr(8'h03, 32'h5);
    rd(8'h03, d); chk(d == 5, "R8 base write in reset", d, 5);
    wr(8'h00, 32'h2);
    make_desc(5, 16'h9C00, 16'd11, 32'hC000_0005, 6'h00, 1);
    make_desc(6, 16'hBC00, 16'd12, 32'hC000_0006, 6'h08, 1);
    wr(8'h04, 32'h0);
    wait_sent(7);
    chk(n_sent == 7, "R8 start from base", n_sent, 7);
    make_desc(5, 16'h9C00, 16'd13, 32'hD000_0005, 6'h00, 1);
    wr(8'h04, 32'h0);
    wait_sent(8);
    chk(n_sent == 8, "R3 wrap to nonzero base", n_sent, 8);

    wr(8'h00, 32'h0);
    make_desc(6, 16'hBC00, 16'd14, 32'hE000_0006, 6'h02, 1);
    wr(8'h04, 32'h0);
    repeat (20) @(negedge clk);
    chk(n_sent == 8 && snd_req == 0, "R9 disabled no request", n_sent, 8);
    wr(8'h00, 32'h2);
    wait_sent(9);
    chk(n_sent == 9, "R9 pending kick after enable", n_sent, 9);

    make_desc(5, 16'h9C00, 16'd15, 32'hF000_0005, 6'h00, 1);
    wr(8'h04, 32'h0);
    for (int i = 0; i < 50 && !snd_req; i++) @(negedge clk);
    make_desc(6, 16'hBC00, 16'd16, 32'hF000_0006, 6'h00, 1);
    wr(8'h04, 32'h0);
    wait_sent(11);
    chk(n_sent == 11, "R4 kick while busy", n_sent, 11);
    chk(exp_q.size() == 0, "R1 all expected sent", exp_q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule